// File: doc/BRIEF.md
# Indirect Memory Access Window

This block gives a host bus access to the two local memories of an embedded controller: a data memory and an instruction memory. The host never addresses either memory directly. For each memory it writes a control register with a start address and the auto-increment options it wants. It then reads or writes a data register over and over, and the block moves its internal word pointer after each access. The block holds both memories as synchronous single-port SRAM models, and their sizes are parameters given in 256-byte blocks.

The instruction memory also keeps, for each 256-byte block, a side entry made of a tag and a secure flag. The host sets the tag of the block the instruction pointer is in through a tag register. Every instruction data write copies the current secure setting of the control register into the side entry of the block it lands in. A debug port reads any side entry by physical block index. After a transfer, the host reads the control register back and compares the pointer with start plus transfer length to confirm the word count. A sticky overflow flag shows that the pointer wrapped past the end of the memory.

Register select codes: 0 data control, 1 data data, 2 instruction control, 3 instruction data, 4 instruction tag, 5 size configuration. Other codes read as zero and ignore writes.

Top module: `mem_window`

## Requirements
- R1: After reset both control registers read 0. ready_o is low whenever req_i is low.
- R2: The size configuration register (select 5) reads the data memory block count in bits [15:0] and the instruction memory block count in bits [31:16].
- R3: Control register layout: bits [15:2] hold the byte address (bits [7:2] the word within a block, bits [15:8] the block index), bit 24 enables increment on write, bit 25 enables increment on read, bit 28 is the secure setting (instruction control only; it reads 0 on data control), bit 29 is the read-only overflow flag. Address bits beyond the memory size read 0, and all other bits read 0.
- R4: A data register write stores the word at the current address. The pointer then advances by one word only if bit 24 is set.
- R5: A data register read returns the word at the current address. ready_o stays low in the first cycle and goes high in the second. After the read completes, the pointer advances by one word only if bit 25 is set.
- R6: Writes and reads of non-data registers complete with ready_o high in the same cycle as req_i.
- R7: An advance from the last word wraps the pointer to 0 and sets the overflow flag. The flag holds until the next write to that control register, which clears it.
- R8: A tag register write stores the value as the tag of the block that holds the current instruction address. A tag register read returns that block's tag, zero-extended.
- R9: Each instruction data write copies control bit 28 into the secure entry of the block it writes, whether that sets or clears the entry.
- R10: The debug port returns the tag and secure entry of the block named on dbg_blk_i, in the same cycle.
- R11: After N auto-incrementing writes from start address S, the control register reads back S + 4N, modulo the memory size.
- R12: An access through one memory's registers leaves the other memory's contents and pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| reg_sel_i | input | 3 | Register select |
| wdata_i | input | 32 | Write data |
| ready_o | output | 1 | Access completes in this cycle |
| rdata_o | output | 32 | Read data, valid with ready_o |
| dbg_blk_i | input | log2(IM_BLOCKS) | Debug physical block index |
| dbg_tag_o | output | TAG_W | Tag of the debug block |
| dbg_sec_o | output | 1 | Secure entry of the debug block |

## Verification
The bench builds the block with 2 data blocks (128 words), 4 instruction blocks (256 words) and 8-bit tags. At these sizes every word of both memories is written and read back in full sweeps, and each sweep carries the pointer across every block boundary and through the wrap at the end. The overflow flag is therefore set and cleared for real, and every side entry is reached through both the tag register and the debug port. The small address widths also make the masking of oversized control writes visible in a single readback.

// File: rtl/mwin_pkg.sv
package mwin_pkg;
  localparam int WORDS_PER_BLK = 64;
  localparam int BIT_INCW      = 24;
  localparam int BIT_INCR      = 25;
  localparam int BIT_SEC       = 28;
  localparam int BIT_OVF       = 29;

  typedef enum logic [2:0] {
    SEL_DM_CTRL = 3'd0,
    SEL_DM_DATA = 3'd1,
    SEL_IM_CTRL = 3'd2,
    SEL_IM_DATA = 3'd3,
    SEL_IM_TAG  = 3'd4,
    SEL_CFG     = 3'd5,
    SEL_RSV6    = 3'd6,
    SEL_RSV7    = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/sp_sram.sv
module sp_sram #(
  parameter int WORDS = 256,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [WORDS];
  logic [DW-1:0] q_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) q_q <= mem_q[addr_i];
  end

  assign rdata_o = q_q;
endmodule

// File: rtl/mwin_port.sv
module mwin_port
  import mwin_pkg::*;
#(
  parameter int NWORDS  = 256,
  parameter bit HAS_SEC = 1'b0,
  localparam int AW     = $clog2(NWORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic [31:0]   ctrl_wdata_i,
  input  logic          step_wr_i,
  input  logic          step_rd_i,
  output logic [AW-1:0] addr_o,
  output logic          inc_w_o,
  output logic          sec_o,
  output logic          ovf_o,
  output logic [31:0]   ctrl_rdata_o
);
  logic [AW-1:0] addr_q;
  logic          incw_q, incr_q, ovf_q;
  logic          step;
  logic          unused_wdata;

  assign unused_wdata = ^ctrl_wdata_i;
  assign step = (step_wr_i & incw_q) | (step_rd_i & incr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      incw_q <= 1'b0;
      incr_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (ctrl_we_i) begin
      addr_q <= ctrl_wdata_i[AW+1:2];
      incw_q <= ctrl_wdata_i[BIT_INCW];
      incr_q <= ctrl_wdata_i[BIT_INCR];
      ovf_q  <= 1'b0;
    end else if (step) begin
      addr_q <= addr_q + 1'b1;
      if (&addr_q) ovf_q <= 1'b1;
    end
  end

  if (HAS_SEC) begin : g_sec
    logic sec_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        sec_q <= 1'b0;
      else if (ctrl_we_i) sec_q <= ctrl_wdata_i[BIT_SEC];
    end
    assign sec_o = sec_q;
  end else begin : g_nosec
    assign sec_o = 1'b0;
  end

  always_comb begin
    ctrl_rdata_o           = '0;
    ctrl_rdata_o[AW+1:2]   = addr_q;
    ctrl_rdata_o[BIT_INCW] = incw_q;
    ctrl_rdata_o[BIT_INCR] = incr_q;
    ctrl_rdata_o[BIT_SEC]  = sec_o;
    ctrl_rdata_o[BIT_OVF]  = ovf_q;
  end

  assign addr_o  = addr_q;
  assign inc_w_o = incw_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/tag_store.sv
module tag_store #(
  parameter int NBLK  = 8,
  parameter int TAG_W = 16,
  localparam int BW   = $clog2(NBLK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tag_we_i,
  input  logic             sec_we_i,
  input  logic [BW-1:0]    blk_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             sec_i,
  output logic [TAG_W-1:0] cur_tag_o,
  input  logic [BW-1:0]    dbg_blk_i,
  output logic [TAG_W-1:0] dbg_tag_o,
  output logic             dbg_sec_o
);
  logic [TAG_W-1:0] tag_q [NBLK];
  logic             sec_q [NBLK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < NBLK; e++) begin
        tag_q[e] <= '0;
        sec_q[e] <= 1'b0;
      end
    end else begin
      if (tag_we_i) tag_q[blk_i] <= tag_i;
      if (sec_we_i) sec_q[blk_i] <= sec_i;
    end
  end

  assign cur_tag_o = tag_q[blk_i];
  assign dbg_tag_o = tag_q[dbg_blk_i];
  assign dbg_sec_o = sec_q[dbg_blk_i];
endmodule

// File: rtl/mem_window.sv
module mem_window
  import mwin_pkg::*;
#(
  parameter int DM_BLOCKS = 4,
  parameter int IM_BLOCKS = 8,
  parameter int TAG_W     = 16,
  localparam int DM_WORDS = DM_BLOCKS * WORDS_PER_BLK,
  localparam int IM_WORDS = IM_BLOCKS * WORDS_PER_BLK,
  localparam int DM_AW    = $clog2(DM_WORDS),
  localparam int IM_AW    = $clog2(IM_WORDS),
  localparam int IM_BW    = $clog2(IM_BLOCKS),
  localparam int OFS_W    = $clog2(WORDS_PER_BLK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [2:0]       reg_sel_i,
  input  logic [31:0]      wdata_i,
  output logic             ready_o,
  output logic [31:0]      rdata_o,
  input  logic [IM_BW-1:0] dbg_blk_i,
  output logic [TAG_W-1:0] dbg_tag_o,
  output logic             dbg_sec_o
);
  reg_sel_e sel;
  logic     is_data, wr, drd, pend_q, rd_issue, rd_done;

  assign sel      = reg_sel_e'(reg_sel_i);
  assign is_data  = (sel == SEL_DM_DATA) || (sel == SEL_IM_DATA);
  assign wr       = req_i & we_i;
  assign drd      = req_i & ~we_i & is_data;
  assign rd_issue = drd & ~pend_q;
  assign rd_done  = drd & pend_q;
  assign ready_o  = req_i & (we_i | ~is_data | pend_q);

  // data reads take two cycles: SRAM issue, then return
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (rd_issue) pend_q <= 1'b1;
    else               pend_q <= 1'b0;
  end

  // data memory side
  logic [DM_AW-1:0] dm_addr;
  logic             dm_inc_w, dm_ovf, unused_dm_sec;
  logic [31:0]      dm_ctrl_rd, dm_q;

  mwin_port #(.NWORDS(DM_WORDS), .HAS_SEC(1'b0)) u_dm_port (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (wr && sel == SEL_DM_CTRL),
    .ctrl_wdata_i (wdata_i),
    .step_wr_i    (wr && sel == SEL_DM_DATA),
    .step_rd_i    (rd_done && sel == SEL_DM_DATA),
    .addr_o       (dm_addr),
    .inc_w_o      (dm_inc_w),
    .sec_o        (unused_dm_sec),
    .ovf_o        (dm_ovf),
    .ctrl_rdata_o (dm_ctrl_rd)
  );

  sp_sram #(.WORDS(DM_WORDS), .DW(32)) u_dm_ram (
    .clk_i   (clk_i),
    .we_i    (wr && sel == SEL_DM_DATA),
    .re_i    (rd_issue && sel == SEL_DM_DATA),
    .addr_i  (dm_addr),
    .wdata_i (wdata_i),
    .rdata_o (dm_q)
  );

  // instruction memory side
  logic [IM_AW-1:0] im_addr;
  logic             im_inc_w, im_ovf, im_sec;
  logic [31:0]      im_ctrl_rd, im_q;
  logic [TAG_W-1:0] im_cur_tag;

  mwin_port #(.NWORDS(IM_WORDS), .HAS_SEC(1'b1)) u_im_port (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (wr && sel == SEL_IM_CTRL),
    .ctrl_wdata_i (wdata_i),
    .step_wr_i    (wr && sel == SEL_IM_DATA),
    .step_rd_i    (rd_done && sel == SEL_IM_DATA),
    .addr_o       (im_addr),
    .inc_w_o      (im_inc_w),
    .sec_o        (im_sec),
    .ovf_o        (im_ovf),
    .ctrl_rdata_o (im_ctrl_rd)
  );

  sp_sram #(.WORDS(IM_WORDS), .DW(32)) u_im_ram (
    .clk_i   (clk_i),
    .we_i    (wr && sel == SEL_IM_DATA),
    .re_i    (rd_issue && sel == SEL_IM_DATA),
    .addr_i  (im_addr),
    .wdata_i (wdata_i),
    .rdata_o (im_q)
  );

  tag_store #(.NBLK(IM_BLOCKS), .TAG_W(TAG_W)) u_tags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tag_we_i  (wr && sel == SEL_IM_TAG),
    .sec_we_i  (wr && sel == SEL_IM_DATA),
    .blk_i     (im_addr[IM_AW-1:OFS_W]),
    .tag_i     (wdata_i[TAG_W-1:0]),
    .sec_i     (im_sec),
    .cur_tag_o (im_cur_tag),
    .dbg_blk_i (dbg_blk_i),
    .dbg_tag_o (dbg_tag_o),
    .dbg_sec_o (dbg_sec_o)
  );

  always_comb begin
    unique case (sel)
      SEL_DM_CTRL: rdata_o = dm_ctrl_rd;
      SEL_DM_DATA: rdata_o = dm_q;
      SEL_IM_CTRL: rdata_o = im_ctrl_rd;
      SEL_IM_DATA: rdata_o = im_q;
      SEL_IM_TAG:  rdata_o = 32'(im_cur_tag);
      SEL_CFG:     rdata_o = {16'(IM_BLOCKS), 16'(DM_BLOCKS)};
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mem_window_chk.sv
module mem_window_chk #(
  parameter int DM_AW = 8,
  parameter int IM_AW = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [2:0]       reg_sel_i,
  input logic             ready_o,
  input logic [DM_AW-1:0] dm_addr,
  input logic             dm_inc_w,
  input logic             dm_ovf,
  input logic [IM_AW-1:0] im_addr,
  input logic             im_inc_w
);
  logic is_data;
  assign is_data = (reg_sel_i == 3'd1) || (reg_sel_i == 3'd3);

  // R6
  fast_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && (we_i || !is_data) |-> ready_o);

  // R1
  no_idle_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> req_i);

  // R5
  read_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && is_data && ready_o |-> $past(req_i && !we_i && !ready_o));

  // R4
  dm_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && reg_sel_i == 3'd1 && dm_inc_w
    |=> dm_addr == $past(dm_addr) + {{(DM_AW-1){1'b0}}, 1'b1});

  // R4
  im_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && reg_sel_i == 3'd3 && im_inc_w
    |=> im_addr == $past(im_addr) + {{(IM_AW-1){1'b0}}, 1'b1});

  // R7
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_ovf && !(req_i && we_i && reg_sel_i == 3'd0) |=> dm_ovf);

  // R12
  dm_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && reg_sel_i <= 3'd1) |=> $stable(dm_addr));
endmodule

bind mem_window mem_window_chk #(.DM_AW(DM_AW), .IM_AW(IM_AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .reg_sel_i (reg_sel_i),
  .ready_o   (ready_o),
  .dm_addr   (dm_addr),
  .dm_inc_w  (dm_inc_w),
  .dm_ovf    (dm_ovf),
  .im_addr   (im_addr),
  .im_inc_w  (im_inc_w)
);

// File: tb/mem_window_tb.sv
module mem_window_tb;
  localparam int DMB = 2;
  localparam int IMB = 4;
  localparam int TW  = 8;
  localparam logic [31:0] INCW = 32'h0100_0000;
  localparam logic [31:0] INCR = 32'h0200_0000;
  localparam logic [31:0] SEC  = 32'h1000_0000;
  localparam logic [31:0] OVF  = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  sel = 3'd0;
  logic [31:0] wdata = '0;
  logic        ready;
  logic [31:0] rdata;
  logic [1:0]  dbg_blk = '0;
  logic [TW-1:0] dbg_tag;
  logic        dbg_sec;

  int checks = 0, fails = 0, ack_miss = 0;

  always #2.5 clk = ~clk;

  mem_window #(.DM_BLOCKS(DMB), .IM_BLOCKS(IMB), .TAG_W(TW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .reg_sel_i(sel),
    .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata),
    .dbg_blk_i(dbg_blk), .dbg_tag_o(dbg_tag), .dbg_sec_o(dbg_sec)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; sel = s; wdata = d;
    #1;
    if (!ready) ack_miss++;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] s, output logic [31:0] d, output int lat);
    @(negedge clk);
    req = 1'b1; we = 1'b0; sel = s;
    lat = 0;
    #1;
    while (!ready) begin
      @(posedge clk); #1;
      lat++;
    end
    d = rdata;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  function automatic logic [31:0] dpat(input int i);
    return 32'h5A00_0000 + i * 32'h0001_0203;
  endfunction

  function automatic logic [31:0] ipat(input int i);
    return 32'hC300_0000 ^ (i * 32'h0009_0007);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int lat, bad, lat_bad;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready idle", {31'b0, ready}, 32'h0);

    bus_rd(3'd0, d, lat); chk("R1 dm ctrl reset", d, 32'h0);
    bus_rd(3'd2, d, lat); chk("R1 im ctrl reset", d, 32'h0);
    chk("R6 ctrl read latency", lat, 0);
    bus_rd(3'd5, d, lat); chk("R2 cfg sizes", d, {16'(IMB), 16'(DMB)});

    // R3 masking and field layout
    bus_wr(3'd0, 32'hFFFF_FFFC);
    bus_rd(3'd0, d, lat); chk("R3 dm ctrl mask", d, 32'h0000_01FC | INCW | INCR);
    bus_wr(3'd2, 32'hFFFF_FFFC);
    bus_rd(3'd2, d, lat); chk("R3 im ctrl mask", d, 32'h0000_03FC | INCW | INCR | SEC);

    // R11 partial transfer count
    bus_wr(3'd0, 32'h40 | INCW);
    for (int i = 0; i < 10; i++) bus_wr(3'd1, dpat(16 + i));
    bus_rd(3'd0, d, lat); chk("R11 readback after 10 words", d, (32'h40 + 40) | INCW);

    // R4 R7 full data sweep with wrap
    bus_wr(3'd0, INCW);
    for (int i = 0; i < DMB * 64; i++) bus_wr(3'd1, dpat(i));
    bus_rd(3'd0, d, lat); chk("R7 dm wrap sets ovf", d, INCW | OVF);
    bus_wr(3'd0, INCR);
    bus_rd(3'd0, d, lat); chk("R7 ctrl write clears ovf", d, INCR);
    bad = 0; lat_bad = 0;
    for (int i = 0; i < DMB * 64; i++) begin
      bus_rd(3'd1, d, lat);
      chk("R5 dm read data", d, dpat(i));
      if (lat != 1) lat_bad++;
    end
    chk("R5 dm read latency", lat_bad, 0);
    bus_rd(3'd0, d, lat); chk("R7 dm read wrap", d, INCR | OVF);

    // R4 R5 no increment
    bus_wr(3'd0, 32'h10);
    bus_wr(3'd1, 32'h1111_1111);
    bus_wr(3'd1, 32'h2222_2222);
    bus_rd(3'd0, d, lat); chk("R4 no advance on write", d, 32'h10);
    bus_rd(3'd1, d, lat); chk("R4 last write kept", d, 32'h2222_2222);
    bus_rd(3'd1, d, lat); chk("R5 repeat read", d, 32'h2222_2222);
    bus_rd(3'd0, d, lat); chk("R5 no advance on read", d, 32'h10);

    // R8 R9 instruction sweep with tags
    for (int b = 0; b < IMB; b++) begin
      bus_wr(3'd2, (b * 256) | INCW | ((b % 2 == 1) ? SEC : 32'h0));
      bus_wr(3'd4, 32'h30 + b);
      for (int i = 0; i < 64; i++) bus_wr(3'd3, ipat(b * 64 + i));
    end
    bus_rd(3'd2, d, lat); chk("R7 im wrap sets ovf", d, INCW | SEC | OVF);
    for (int b = 0; b < IMB; b++) begin
      @(negedge clk); dbg_blk = 2'(b); #1;
      chk("R10 dbg tag", 32'(dbg_tag), 32'h30 + b);
      chk("R9 dbg secure", {31'b0, dbg_sec}, (b % 2 == 1) ? 32'h1 : 32'h0);
    end
    bus_wr(3'd2, 32'h200);
    bus_rd(3'd4, d, lat); chk("R8 tag read block 2", d, 32'h32);

    // R9 clearing a secure entry
    bus_wr(3'd2, 32'h100 | INCW);
    bus_wr(3'd3, 32'hDEAD_0001);
    @(negedge clk); dbg_blk = 2'd1; #1;
    chk("R9 secure cleared", {31'b0, dbg_sec}, 32'h0);
    chk("R10 tag unchanged by data", 32'(dbg_tag), 32'h31);

    bus_wr(3'd2, INCR);
    lat_bad = 0;
    for (int i = 0; i < IMB * 64; i++) begin
      bus_rd(3'd3, d, lat);
      chk("R5 im read data", d, (i == 64) ? 32'hDEAD_0001 : ipat(i));
      if (lat != 1) lat_bad++;
    end
    chk("R5 im read latency", lat_bad, 0);

    // R12 data memory and pointer untouched by instruction traffic
    bus_rd(3'd0, d, lat); chk("R12 dm pointer kept", d, 32'h10);
    bus_wr(3'd0, INCR);
    for (int i = 0; i < 4; i++) begin
      bus_rd(3'd1, d, lat);
      chk("R12 dm content kept", d, dpat(i));
    end

    chk("R6 immediate ack count", ack_miss, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule